// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Context Stack

This block arbitrates twelve interrupt sources for a small processor core. Each source has a fixed priority, and a lower index wins. Source 0 is the reset request and source 1 is the powerdown request. The per-source mask does not gate these two; it gates the remaining ten. A global enable flag sits above the mask. Clearing the flag stops every source except source 0 and leaves the mask register untouched. Software can raise or cancel the pending state of the upper eight sources through a 16-bit set/clear write. A control write chooses, per source, whether the input is treated as a level or as a rising edge. The same write chooses whether an interrupt may pre-empt one that is already being serviced.

On acceptance, the controller saves the core's context: the current mask, a 7-bit mode word and an 8-bit arithmetic flag word go into a 12-entry, 25-bit hardware stack. It then raises a one-cycle vector pulse that carries the source index. A return command retires the most recent service and pops the stack. The pop reloads the mask and hands the saved mode and flag words back to the core. The core can also push and pop the stack on its own. Overflow and empty conditions are reported.

Top module: `irq_ctrl_core`

## Requirements
- R1: After reset, the design is in this state:
  - the mask register is zero;
  - no vector is signalled;
  - the stack is empty, and neither full nor overflowed;
  - no restore is signalled;
  - the global enable is set;
  - nesting is off;
  - every source is level sensitive.
- R2: The vector id equals the source index (0 to 11). Sources 0 and 1 are never gated by the mask. Source i, for i of 2 or more, can be taken only while mask bit i-2 is 1.
- R3: Among requests that are enabled, the lowest index is taken. A level request present before a clock edge is taken at that edge. `vec_valid` is high for exactly the one following cycle.
- R4: While the global enable is clear (after `gie_clr`), sources 1 to 11 are never taken and the mask register keeps its value. Source 0 is still taken. `gie_set` restores normal service; `gie_clr` wins over `gie_set` in the same cycle.
- R5: Each acceptance pushes one entry. Bits [24:15] hold the mask, [14:8] hold `mode_in` and [7:0] hold `arith_in`, all sampled in the accepting cycle.
- R6: The stack holds 12 entries. `stk_push` stores an entry built as in R5. A push while full is dropped and sets `stk_ovf`, which stays set until reset. `stk_full` and `stk_empty` show the fill level.
- R7: A pop is either `rti` or `stk_pop`. When the stack is not empty, a pop loads the mask from the top entry. In the next cycle it shows that entry's mode and arithmetic fields, with `rest_valid` high. A pop on an empty stack does nothing.
- R8: With nesting off, nothing is taken while any service is active. With nesting on, only a source of strictly lower index than the most recent active service is taken. `rti` retires the most recent active service.
- R9: When control bit `ctl_edge[i]` is 1, a rising edge on `irq_in[i]` latches a pending request. That request can be taken at the following edge. It stays latched while blocked and clears when taken; a held-high input does not request again. When the bit is 0, the input requests only while it is high.
- R10: A `sw_wr` write uses bit 8+k to set, and bit k to clear, the pending latch of source 4+k (k from 0 to 7). The latch is set at the write edge, and clear wins over set.
- R11: In a cycle with `rti`, `stk_push` or `stk_pop` high, no interrupt is taken; a request still present is taken on a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 12 | Request inputs, index = source |
| mask_wr | input | 1 | Write the mask register |
| mask_wdata | input | 10 | New mask, bit j gates source j+2 |
| sw_wr | input | 1 | Software set/clear write |
| sw_wdata | input | 16 | [15:8] set, [7:0] clear, for sources 4..11 |
| ctl_wr | input | 1 | Write the control register |
| ctl_nest | input | 1 | 1 allows pre-emption |
| ctl_edge | input | 12 | Per-source edge (1) or level (0) |
| gie_set | input | 1 | Set global enable |
| gie_clr | input | 1 | Clear global enable |
| mode_in | input | 7 | Core mode word to save |
| arith_in | input | 8 | Core arithmetic flags to save |
| rti | input | 1 | Return from interrupt |
| stk_push | input | 1 | Manual push |
| stk_pop | input | 1 | Manual pop |
| vec_valid | output | 1 | One-cycle vector request |
| vec_id | output | 4 | Accepted source index |
| irq_mask | output | 10 | Current mask register |
| rest_valid | output | 1 | Restored words valid |
| rest_mode | output | 7 | Restored mode word |
| rest_arith | output | 8 | Restored arithmetic flags |
| stk_empty | output | 1 | Stack empty |
| stk_full | output | 1 | Stack full |
| stk_ovf | output | 1 | Sticky overflow |

## Verification
The stack checks assume the core never asserts a push and a pop together. The top also never combines `rti` with `stk_push`. The stimulus keeps those commands single-cycle and one at a time. The nesting and mask-stability properties further assume that returns are issued only after a vector has been taken. The stimulus keeps to this by only pulsing `rti` after observing a vector or a manual push. Level inputs are always dropped before the matching return, so that a held line cannot re-enter immediately.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int IRQ_NSRC   = 12;
    localparam int IRQ_SWN    = 8;
    localparam int IRQ_MODEW  = 7;
    localparam int IRQ_ARITHW = 8;
    localparam int IRQ_DEPTH  = 12;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N = 12,
    localparam int IDW = $clog2(N)
) (
    input  logic [N-1:0]   req,
    output logic           any,
    output logic [IDW-1:0] idx,
    output logic [N-1:0]   oh
);
    always_comb begin
        any = |req;
        idx = '0;
        oh  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx   = IDW'(i);
                oh    = '0;
                oh[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_src_pend.sv
module irq_src_pend #(
    parameter int N   = 12,
    parameter int SWN = 8,
    localparam int BASE = N - SWN
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   irq_in,
    input  logic [N-1:0]   edge_sel,
    input  logic           sw_wr,
    input  logic [SWN-1:0] sw_set,
    input  logic [SWN-1:0] sw_clr,
    input  logic [N-1:0]   take_oh,
    output logic [N-1:0]   req
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;
    logic [N-1:0] set_v, clr_v;

    for (genvar i = 0; i < N; i++) begin : g_src
        logic edge_hit;
        assign edge_hit = edge_sel[i] & irq_in[i] & ~st_q.prev[i];
        if (i >= BASE) begin : g_sw
            assign set_v[i] = edge_hit | (sw_wr & sw_set[i-BASE]);
            assign clr_v[i] = sw_wr & sw_clr[i-BASE];
        end else begin : g_hw
            assign set_v[i] = edge_hit;
            assign clr_v[i] = 1'b0;
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = irq_in;
        st_d.pend = ((st_q.pend & ~take_oh) | set_v) & ~clr_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req = st_q.pend | (~edge_sel & irq_in);
endmodule

// File: rtl/irq_stat_stack.sv
module irq_stat_stack #(
    parameter int W     = 25,
    parameter int DEPTH = 12,
    localparam int CNTW = $clog2(DEPTH + 1),
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    top,
    output logic [CNTW-1:0] cnt,
    output logic            empty,
    output logic            full,
    output logic            ovf
);
    localparam logic [CNTW-1:0] LIM = CNTW'(DEPTH);
    localparam logic [CNTW-1:0] ONE = CNTW'(1);

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic            ovf;
    } stk_st_t;

    stk_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic [CNTW-1:0] tidx;

    always_comb begin
        st_d = st_q;
        if (push) begin
            if (st_q.cnt == LIM) st_d.ovf = 1'b1;
            else                 st_d.cnt = st_q.cnt + ONE;
        end else if (pop && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && st_q.cnt != LIM) mem[st_q.cnt[IDXW-1:0]] <= wdata;
    end

    assign tidx  = st_q.cnt - ONE;
    assign top   = (st_q.cnt == '0) ? '0 : mem[tidx[IDXW-1:0]];
    assign cnt   = st_q.cnt;
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == LIM);
    assign ovf   = st_q.ovf;

    assert_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LIM);
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    assert_cmd_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/irq_ctrl_core.sv
module irq_ctrl_core
    import irq_pkg::*;
#(
    parameter int NSRC   = IRQ_NSRC,
    parameter int SWN    = IRQ_SWN,
    parameter int MODEW  = IRQ_MODEW,
    parameter int ARITHW = IRQ_ARITHW,
    parameter int DEPTH  = IRQ_DEPTH,
    localparam int MASKW = NSRC - 2,
    localparam int STKW  = MASKW + MODEW + ARITHW,
    localparam int IDW   = $clog2(NSRC),
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_in,
    input  logic              mask_wr,
    input  logic [MASKW-1:0]  mask_wdata,
    input  logic              sw_wr,
    input  logic [2*SWN-1:0]  sw_wdata,
    input  logic              ctl_wr,
    input  logic              ctl_nest,
    input  logic [NSRC-1:0]   ctl_edge,
    input  logic              gie_set,
    input  logic              gie_clr,
    input  logic [MODEW-1:0]  mode_in,
    input  logic [ARITHW-1:0] arith_in,
    input  logic              rti,
    input  logic              stk_push,
    input  logic              stk_pop,
    output logic              vec_valid,
    output logic [IDW-1:0]    vec_id,
    output logic [MASKW-1:0]  irq_mask,
    output logic              rest_valid,
    output logic [MODEW-1:0]  rest_mode,
    output logic [ARITHW-1:0] rest_arith,
    output logic              stk_empty,
    output logic              stk_full,
    output logic              stk_ovf
);
    typedef struct packed {
        logic [MASKW-1:0]  mask;
        logic              nest;
        logic [NSRC-1:0]   edge_sel;
        logic              gie;
        logic [NSRC-1:0]   isr;
        logic              vv;
        logic [IDW-1:0]    vid;
        logic              rv;
        logic [MODEW-1:0]  rmode;
        logic [ARITHW-1:0] rarith;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [NSRC-1:0] req, en, win_oh, isr_oh;
    logic [IDW-1:0]  win_idx, isr_idx;
    logic            win_any, isr_any, allowed, take, cmd;
    logic            push_any, pop_any, pop_ok;
    logic [STKW-1:0] stk_top, stk_wdata;
    logic [CNTW-1:0] stk_cnt;

    irq_src_pend #(.N(NSRC), .SWN(SWN)) u_pend (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .edge_sel(st_q.edge_sel),
        .sw_wr(sw_wr), .sw_set(sw_wdata[2*SWN-1:SWN]), .sw_clr(sw_wdata[SWN-1:0]),
        .take_oh(take ? win_oh : '0), .req(req)
    );

    // Enable per source: 0 always, 1 by global flag, others by flag and mask.
    for (genvar i = 0; i < NSRC; i++) begin : g_en
        if (i == 0) begin : g_rst
            assign en[i] = 1'b1;
        end else if (i == 1) begin : g_pd
            assign en[i] = st_q.gie;
        end else begin : g_user
            assign en[i] = st_q.gie & st_q.mask[i-2];
        end
    end

    irq_prio_pick #(.N(NSRC)) u_win (
        .req(req & en), .any(win_any), .idx(win_idx), .oh(win_oh)
    );
    irq_prio_pick #(.N(NSRC)) u_isr (
        .req(st_q.isr), .any(isr_any), .idx(isr_idx), .oh(isr_oh)
    );

    assign cmd      = rti | stk_push | stk_pop;
    assign allowed  = !isr_any || (st_q.nest && (win_oh < isr_oh));
    assign take     = win_any & allowed & ~cmd;
    assign push_any = take | stk_push;
    assign pop_any  = (rti | stk_pop) & ~stk_push;
    assign pop_ok   = pop_any & ~stk_empty;
    assign stk_wdata = {st_q.mask, mode_in, arith_in};

    irq_stat_stack #(.W(STKW), .DEPTH(DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(push_any), .pop(pop_any),
        .wdata(stk_wdata), .top(stk_top), .cnt(stk_cnt),
        .empty(stk_empty), .full(stk_full), .ovf(stk_ovf)
    );

    always_comb begin
        st_d    = st_q;
        st_d.vv = take;
        if (take) st_d.vid = win_idx;
        if (pop_ok)       st_d.mask = stk_top[STKW-1 -: MASKW];
        else if (mask_wr) st_d.mask = mask_wdata;
        if (ctl_wr) begin
            st_d.nest     = ctl_nest;
            st_d.edge_sel = ctl_edge;
        end
        if (gie_clr)      st_d.gie = 1'b0;
        else if (gie_set) st_d.gie = 1'b1;
        st_d.isr = (st_q.isr & ~(rti ? isr_oh : '0)) | (take ? win_oh : '0);
        st_d.rv  = pop_ok;
        if (pop_ok) begin
            st_d.rmode  = stk_top[ARITHW +: MODEW];
            st_d.rarith = stk_top[ARITHW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.gie <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_valid  = st_q.vv;
    assign vec_id     = st_q.vid;
    assign irq_mask   = st_q.mask;
    assign rest_valid = st_q.rv;
    assign rest_mode  = st_q.rmode;
    assign rest_arith = st_q.rarith;

    assert_no_nest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.nest && st_q.isr != '0) |=> !vec_valid);
    assert_pd_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.gie |=> !(vec_valid && vec_id != '0));
    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_wr && !rti && !stk_pop) |=> $stable(irq_mask));
    assert_push_on_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (($past(stk_cnt) != CNTW'(DEPTH))
                       ? (stk_cnt == CNTW'($past(stk_cnt) + 1'b1)) : stk_ovf));
endmodule

// File: tb/irq_ctrl_core_tb.sv
module irq_ctrl_core_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] irq_in = '0;
    logic        mask_wr = 1'b0;
    logic [9:0]  mask_wdata = '0;
    logic        sw_wr = 1'b0;
    logic [15:0] sw_wdata = '0;
    logic        ctl_wr = 1'b0, ctl_nest = 1'b0;
    logic [11:0] ctl_edge = '0;
    logic        gie_set = 1'b0, gie_clr = 1'b0;
    logic [6:0]  mode_in = '0;
    logic [7:0]  arith_in = '0;
    logic        rti = 1'b0, stk_push = 1'b0, stk_pop = 1'b0;
    logic        vec_valid, rest_valid, stk_empty, stk_full, stk_ovf;
    logic [3:0]  vec_id;
    logic [9:0]  irq_mask;
    logic [6:0]  rest_mode;
    logic [7:0]  rest_arith;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    irq_ctrl_core u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .ctl_wr(ctl_wr), .ctl_nest(ctl_nest), .ctl_edge(ctl_edge),
        .gie_set(gie_set), .gie_clr(gie_clr), .mode_in(mode_in),
        .arith_in(arith_in), .rti(rti), .stk_push(stk_push), .stk_pop(stk_pop),
        .vec_valid(vec_valid), .vec_id(vec_id), .irq_mask(irq_mask),
        .rest_valid(rest_valid), .rest_mode(rest_mode), .rest_arith(rest_arith),
        .stk_empty(stk_empty), .stk_full(stk_full), .stk_ovf(stk_ovf)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic expect_vec(input bit exp, input int id, input string tag);
        int act;
        act = vec_valid ? int'(vec_id) : -1;
        chk(vec_valid == exp && (!exp || int'(vec_id) == id), tag, act, exp ? id : -1);
    endtask

    task automatic set_mask(input logic [9:0] m);
        mask_wdata = m; mask_wr = 1'b1; step(); mask_wr = 1'b0;
    endtask

    task automatic set_ctl(input logic nest, input logic [11:0] edg);
        ctl_nest = nest; ctl_edge = edg; ctl_wr = 1'b1; step(); ctl_wr = 1'b0;
    endtask

    task automatic pulse_rti();
        rti = 1'b1; step(); rti = 1'b0;
    endtask

    task automatic sw_write(input logic [15:0] v);
        sw_wdata = v; sw_wr = 1'b1; step(); sw_wr = 1'b0;
    endtask

    function automatic int lowest(input logic [11:0] v);
        for (int i = 11; i >= 0; i--) if (v[i]) lowest = i;
    endfunction

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(irq_mask == 0, "R1 mask", irq_mask, 0);
        chk(!vec_valid && !rest_valid, "R1 idle", vec_valid, 0);
        chk(stk_empty && !stk_full && !stk_ovf, "R1 stack", stk_empty, 1);

        // R2/R3 every source alone, all unmasked
        set_mask(10'h3FF);
        for (int i = 0; i < 12; i++) begin
            irq_in = 12'(1) << i; step();
            expect_vec(1'b1, i, "R2 single");
            irq_in = '0; step();
            expect_vec(1'b0, 0, "R3 pulse");
            pulse_rti();
            chk(rest_valid && stk_empty, "R7 pop", stk_empty, 1);
        end

        // R2 each maskable source blocked by its own bit
        for (int i = 2; i < 12; i++) begin
            set_mask(~(10'(1) << (i - 2)));
            irq_in = 12'(1) << i; step();
            expect_vec(1'b0, 0, "R2 masked");
            step();
            expect_vec(1'b0, 0, "R2 masked");
            irq_in = '0;
        end
        set_mask(10'h000);
        for (int i = 0; i < 2; i++) begin
            irq_in = 12'(1) << i; step();
            expect_vec(1'b1, i, "R2 unmaskable");
            irq_in = '0; step(); pulse_rti();
        end

        // R3 priority sweep
        set_mask(10'h3FF);
        for (int p = 1; p < 4096; p += 83) begin
            irq_in = 12'(p); step();
            expect_vec(1'b1, lowest(12'(p)), "R3 prio");
            irq_in = '0; step(); pulse_rti();
        end

        // R4 global disable
        gie_clr = 1'b1; step(); gie_clr = 1'b0;
        irq_in = 12'h002; step();
        expect_vec(1'b0, 0, "R4 pd blocked"); step();
        expect_vec(1'b0, 0, "R4 pd blocked");
        irq_in = 12'h020; step();
        expect_vec(1'b0, 0, "R4 user blocked");
        chk(irq_mask == 10'h3FF, "R4 mask kept", irq_mask, 10'h3FF);
        irq_in = 12'h001; step();
        expect_vec(1'b1, 0, "R4 reset src");
        irq_in = '0; step(); pulse_rti();
        gie_set = 1'b1; step(); gie_set = 1'b0;
        irq_in = 12'h002; step();
        expect_vec(1'b1, 1, "R4 reenable");
        irq_in = '0; step(); pulse_rti();

        // R5/R7 context saved and mask restored
        mode_in = 7'h55; arith_in = 8'hA3;
        irq_in = 12'h020; step();
        expect_vec(1'b1, 5, "R5 take");
        chk(!stk_empty, "R5 pushed", stk_empty, 0);
        irq_in = '0; mode_in = '0; arith_in = '0;
        set_mask(10'h000);
        chk(irq_mask == 0, "R7 mask written", irq_mask, 0);
        pulse_rti();
        chk(irq_mask == 10'h3FF, "R7 mask restore", irq_mask, 10'h3FF);
        chk(rest_valid && rest_mode == 7'h55, "R5 mode", rest_mode, 7'h55);
        chk(rest_arith == 8'hA3, "R5 arith", rest_arith, 8'hA3);

        // R9 edge mode on source 6
        set_ctl(1'b0, 12'h040);
        irq_in = 12'h040; step();
        expect_vec(1'b0, 0, "R9 latch cycle"); step();
        expect_vec(1'b1, 6, "R9 edge take"); step();
        expect_vec(1'b0, 0, "R9 once");
        pulse_rti(); step(); step();
        expect_vec(1'b0, 0, "R9 held no retrigger");
        irq_in = '0;
        irq_in = 12'h008; step();
        expect_vec(1'b1, 3, "R9 level take");
        irq_in = 12'h048; step();
        irq_in = '0; step();
        expect_vec(1'b0, 0, "R9 blocked while busy");
        pulse_rti(); step();
        expect_vec(1'b1, 6, "R9 latched kept");
        pulse_rti();
        set_ctl(1'b0, 12'h000);

        // R10 software force per source
        for (int k = 0; k < 8; k++) begin
            sw_write(16'(1) << (8 + k));
            expect_vec(1'b0, 0, "R10 set edge"); step();
            expect_vec(1'b1, 4 + k, "R10 force");
            pulse_rti();
        end
        gie_clr = 1'b1; step(); gie_clr = 1'b0;
        sw_write(16'h2000);
        sw_write(16'h0020);
        gie_set = 1'b1; step(); gie_set = 1'b0; step(); step();
        expect_vec(1'b0, 0, "R10 cleared");
        sw_write(16'h2020); step(); step();
        expect_vec(1'b0, 0, "R10 clear wins");

        // R8 nesting on
        set_ctl(1'b1, 12'h000);
        mode_in = 7'd11;
        irq_in = 12'h080; step();
        expect_vec(1'b1, 7, "R8 first"); step();
        expect_vec(1'b0, 0, "R8 same level");
        irq_in = 12'h280; step();
        expect_vec(1'b0, 0, "R8 lower blocked");
        mode_in = 7'd22;
        irq_in = 12'h288; step();
        expect_vec(1'b1, 3, "R8 preempt");
        irq_in = 12'h280;
        pulse_rti();
        chk(rest_mode == 7'd22, "R8 lifo", rest_mode, 22); step();
        expect_vec(1'b0, 0, "R8 still busy");
        irq_in = 12'h200;
        pulse_rti();
        chk(rest_mode == 7'd11, "R8 lifo", rest_mode, 11); step();
        expect_vec(1'b1, 9, "R8 after return");
        irq_in = '0; pulse_rti();
        // R8 nesting off
        set_ctl(1'b0, 12'h000);
        irq_in = 12'h080; step();
        expect_vec(1'b1, 7, "R8 off first");
        irq_in = 12'h088; step();
        expect_vec(1'b0, 0, "R8 off no preempt"); step();
        expect_vec(1'b0, 0, "R8 off no preempt");
        irq_in = '0; pulse_rti();

        // R11 stack command blocks acceptance
        irq_in = 12'h010; stk_push = 1'b1; step(); stk_push = 1'b0;
        expect_vec(1'b0, 0, "R11 blocked"); step();
        expect_vec(1'b1, 4, "R11 later");
        irq_in = '0; pulse_rti();
        stk_pop = 1'b1; step(); stk_pop = 1'b0;
        chk(stk_empty, "R11 drained", stk_empty, 1);

        // R6/R7 manual fill, overflow, drain
        for (int k = 0; k < 12; k++) begin
            mode_in = 7'(k); arith_in = 8'(k + 100);
            stk_push = 1'b1; step(); stk_push = 1'b0;
        end
        chk(stk_full && !stk_ovf, "R6 full", stk_full, 1);
        stk_push = 1'b1; step(); stk_push = 1'b0;
        chk(stk_ovf && stk_full, "R6 overflow", stk_ovf, 1);
        for (int k = 11; k >= 0; k--) begin
            stk_pop = 1'b1; step(); stk_pop = 1'b0;
            chk(rest_valid && int'(rest_mode) == k, "R7 manual pop", rest_mode, k);
            chk(int'(rest_arith) == k + 100, "R7 manual arith", rest_arith, k + 100);
        end
        chk(stk_empty && !stk_full, "R6 empty", stk_empty, 1);
        stk_pop = 1'b1; step(); stk_pop = 1'b0;
        chk(!rest_valid, "R7 empty pop", rest_valid, 0);
        chk(stk_ovf, "R6 sticky", stk_ovf, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule